// File: doc/BRIEF.md
# Serial Synthesizer Programming Interface

This block receives a three-wire serial stream (data, serial clock, load enable) and uses it to program the two parameter registers of a pulse-swallow frequency synthesizer. Both words arrive through the same port. Data enters most significant bit first, one bit for each rising edge of the serial clock. The last bit shifted in is a destination flag. A rising edge of load enable then copies the word into the register that the flag selects. The reference register holds a prescaler modulus select and a 14-bit reference ratio. The main register holds an 11-bit main count and a 7-bit swallow count.

All three serial inputs are oversampled in the system clock domain through two-flop synchronisers. The latched values drive the synthesizer counters directly. A fast-lock switch enable follows load enable, so the loop filter can be shortened while a new channel is loaded. A word that carries an illegal setting is still latched, and it raises a sticky error flag. The flag stays set until a later legal load.

Top module: `synth_serial_prog`

## Requirements
- R1: After reset, ref_ratio, prescale_sel, swallow_cnt and main_cnt are all 0, config_error is 0 and fastlock_en is 1. The load enable synchroniser resets to the high (undriven) level, so no transfer happens until load enable rises.
- R2: Each rising edge of ser_clk shifts ser_data into a 19-bit shift register, most significant bit first. Shifting alone, without a rising edge of ser_load, leaves every latched output unchanged.
- R3: A reference word is 16 bits, sent in this order: prescaler select, ratio bit 13 down to bit 0, then the control bit 1. On load, prescale_sel takes the select bit (1 = 32/33 modulus, 0 = 64/65 modulus) and ref_ratio takes the 14 ratio bits. swallow_cnt and main_cnt are unchanged.
- R4: A main word is 19 bits, sent in this order: main count bit 10 down to 0, swallow bit 6 down to 0, then the control bit 0. On load, main_cnt and swallow_cnt take those fields. ref_ratio and prescale_sel are unchanged.
- R5: A transfer happens only on a rising edge of ser_load. The new values are visible at the outputs within 4 system clocks of that edge. Holding ser_load high, or letting it fall, changes nothing.
- R6: fastlock_en follows ser_load, delayed by the two synchroniser stages.
- R7: A reference load with a ratio below 8 sets config_error, and the value is still latched.
- R8: A main load with main count below 16, or with swallow bit 6 set, sets config_error, and the values are still latched.
- R9: config_error stays set until the next legal load of either word, which clears it.
- R10: For a reference load, only the last 16 bits shifted in are used. Any earlier bits still held in the shift register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock; data is shifted on its rising edge |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_load | input | 1 | Load enable; its rising edge transfers the word |
| ref_ratio | output | 14 | Latched reference divide ratio |
| prescale_sel | output | 1 | Latched prescaler select (1 = 32/33 modulus) |
| swallow_cnt | output | 7 | Latched swallow count |
| main_cnt | output | 11 | Latched main count |
| fastlock_en | output | 1 | Fast-lock switch enable, follows load enable |
| config_error | output | 1 | Sticky flag: the last load was illegal |

## Verification
A wrong bit alignment in the shift register shows up as a scaled or shifted field value at the ports, 4 system clocks after the load edge. For that reason, the tests use field values that are asymmetric and placed near their boundaries. A wrong destination decode shows as the other register changing, so every load also checks the register it should not touch. A defect in the error flag shows only as config_error holding the wrong level after a load. The tests therefore step it through set, hold and clear across mixed legal and illegal loads.

// File: rtl/synth_serial_prog.sv
module synth_serial_prog #(
  parameter int REF_W  = 14,
  parameter int SWAL_W = 7,
  parameter int MAIN_W = 11,
  parameter int REF_MIN  = 8,
  parameter int MAIN_MIN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_load,
  output logic [REF_W-1:0]  ref_ratio,
  output logic              prescale_sel,
  output logic [SWAL_W-1:0] swallow_cnt,
  output logic [MAIN_W-1:0] main_cnt,
  output logic              fastlock_en,
  output logic              config_error
);
  localparam int SR_W = MAIN_W + SWAL_W + 1;

  logic [2:0] clk_sy, ld_sy;
  logic [1:0] dat_sy;
  logic [SR_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_sy <= '0;
      ld_sy  <= '1;
      dat_sy <= '0;
    end else begin
      clk_sy <= {clk_sy[1:0], ser_clk};
      ld_sy  <= {ld_sy[1:0], ser_load};
      dat_sy <= {dat_sy[0], ser_data};
    end

  wire sclk_rise = clk_sy[1] & ~clk_sy[2];
  wire ld_rise   = ld_sy[1] & ~ld_sy[2];
  wire to_ref    = sr[0];

  wire [REF_W-1:0]  nxt_ref  = sr[REF_W:1];
  wire              nxt_pre  = sr[REF_W+1];
  wire [SWAL_W-1:0] nxt_swal = sr[SWAL_W:1];
  wire [MAIN_W-1:0] nxt_main = sr[SR_W-1:SWAL_W+1];

  wire ref_bad  = nxt_ref < REF_W'(REF_MIN);
  wire main_bad = (nxt_main < MAIN_W'(MAIN_MIN)) | nxt_swal[SWAL_W-1];

  assign fastlock_en = ld_sy[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sr <= '0;
    else if (sclk_rise) sr <= {sr[SR_W-2:0], dat_sy[1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ref_ratio    <= '0;
      prescale_sel <= 1'b0;
      swallow_cnt  <= '0;
      main_cnt     <= '0;
      config_error <= 1'b0;
    end else if (ld_rise) begin
      if (to_ref) begin
        ref_ratio    <= nxt_ref;
        prescale_sel <= nxt_pre;
        config_error <= ref_bad;
      end else begin
        swallow_cnt  <= nxt_swal;
        main_cnt     <= nxt_main;
        config_error <= main_bad;
      end
    end

  // R5
  hold_without_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_rise |=> $stable({ref_ratio, prescale_sel, swallow_cnt, main_cnt, config_error}));
  // R3
  ref_load_keeps_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rise && sr[0] |=> $stable({swallow_cnt, main_cnt}));
  // R4
  main_load_keeps_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rise && !sr[0] |=> $stable({ref_ratio, prescale_sel}));
  // R4
  main_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rise && !sr[0] |=> main_cnt == $past(sr[SR_W-1:SWAL_W+1]));
  // R8
  main_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rise && !sr[0] && sr[SWAL_W] |=> config_error);
  // R9
  error_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(config_error) |-> $past(ld_rise));
endmodule

// File: tb/sim_synth_serial_prog.sv
module sim_synth_serial_prog;
  logic clk = 0, rst_n = 0, ser_clk = 0, ser_data = 0, ser_load = 1;
  logic [13:0] ref_ratio;
  logic prescale_sel, fastlock_en, config_error;
  logic [6:0] swallow_cnt;
  logic [10:0] main_cnt;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  synth_serial_prog u0 (.clk, .rst_n, .ser_clk, .ser_data, .ser_load,
    .ref_ratio, .prescale_sel, .swallow_cnt, .main_cnt, .fastlock_en, .config_error);

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic shift(logic [18:0] w, int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = w[i];
      tick(3);
      ser_clk = 1;
      tick(3);
      ser_clk = 0;
    end
  endtask

  task automatic load_word(logic [18:0] w, int n);
    ser_load = 0;
    tick(4);
    shift(w, n);
    tick(2);
    ser_load = 1;
    tick(5);
  endtask

  task automatic send_ref(logic sw, logic [13:0] r);
    load_word({3'b000, sw, r, 1'b1}, 16);
  endtask

  task automatic send_main(logic [10:0] n, logic [6:0] a);
    load_word({n, a, 1'b0}, 19);
  endtask

  task automatic t_reset;
    check("R1 ref_ratio", ref_ratio, 0);
    check("R1 main_cnt", main_cnt, 0);
    check("R1 swallow_cnt", swallow_cnt, 0);
    check("R1 config_error", config_error, 0);
    check("R1 fastlock_en", fastlock_en, 1);
  endtask

  task automatic t_ref_load;
    send_ref(1, 14'd1000);
    check("R3 ref_ratio", ref_ratio, 1000);
    check("R3 prescale_sel", prescale_sel, 1);
    check("R3 main untouched", main_cnt, 0);
    check("R6 fastlock high", fastlock_en, 1);
    send_ref(0, 14'd16383);
    check("R3 ref_ratio max", ref_ratio, 16383);
    check("R3 prescale_sel 0", prescale_sel, 0);
  endtask

  task automatic t_main_load;
    send_main(11'd1234, 7'd37);
    check("R4 main_cnt", main_cnt, 1234);
    check("R4 swallow_cnt", swallow_cnt, 37);
    check("R4 ref untouched", ref_ratio, 16383);
    check("R4 error clear", config_error, 0);
  endtask

  task automatic t_no_load;
    ser_load = 0;
    tick(4);
    check("R6 fastlock low", fastlock_en, 0);
    shift({11'd20, 7'd5, 1'b0}, 19);
    tick(4);
    check("R2 main held", main_cnt, 1234);
    check("R2 swallow held", swallow_cnt, 37);
    ser_load = 1;
    tick(5);
    check("R5 load after shift", main_cnt, 20);
    tick(20);
    check("R5 held while high", main_cnt, 20);
    ser_load = 0;
    tick(10);
    check("R5 fall no change", main_cnt, 20);
    ser_load = 1;
    tick(5);
  endtask

  task automatic t_errors;
    send_ref(1, 14'd8);
    check("R7 ratio 8 legal", config_error, 0);
    send_ref(1, 14'd7);
    check("R7 ratio 7 flagged", config_error, 1);
    check("R7 ratio 7 latched", ref_ratio, 7);
    ser_load = 0; tick(4); ser_load = 1; tick(5);
    check("R9 sticky on reload", config_error, 1);
    send_main(11'd16, 7'd63);
    check("R9 cleared by legal", config_error, 0);
    check("R8 boundary latched", main_cnt, 16);
    send_main(11'd15, 7'd2);
    check("R8 main 15 flagged", config_error, 1);
    check("R8 main 15 latched", main_cnt, 15);
    send_ref(0, 14'd500);
    check("R9 cleared by ref", config_error, 0);
    send_main(11'd300, 7'd64);
    check("R8 swallow bit6 flagged", config_error, 1);
    check("R8 swallow latched", swallow_cnt, 64);
  endtask

  task automatic t_leading_bits;
    ser_load = 0;
    tick(4);
    shift(19'h7FFFF, 19);
    shift({3'b000, 1'b0, 14'd4660, 1'b1}, 16);
    ser_load = 1;
    tick(5);
    check("R10 ref_ratio", ref_ratio, 4660);
    check("R10 prescale_sel", prescale_sel, 0);
    check("R10 main untouched", main_cnt, 300);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(4);
    t_reset;
    t_ref_load;
    t_main_load;
    t_no_load;
    t_errors;
    t_leading_bits;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule